// File: doc/BRIEF.md
# DMA Request Splitter

The splitter takes one DMA job at a time (a start byte address up to 64 bits wide, a byte length, a read/write direction and an IO-space flag) and turns it into a stream of request descriptors. Each descriptor covers one contiguous chunk of the job. It carries the chunk address, the byte length, the number of dwords spanned, the first and last dword byte enables, and a flag that selects the 64-bit request format.

Three limits set the chunk length, and the smallest one wins: the bytes still owed to the job, the transfer size limit less the byte offset of the chunk inside its dword, and the distance to the next 4 KiB address boundary. The size limit is 128 bytes shifted left by a 3-bit code. Writes use the payload-size code and reads use the read-request code. Both codes are captured when the job is accepted.

In IO mode each chunk stays inside one dword. Jobs enter on a valid/ready pair and descriptors leave on a valid/ready pair. A new job is taken only when the previous one has been fully emitted.

Top module: `dma_req_splitter`

## Requirements
- R1: The chunk size limit in bytes is 128 << code. Writes (job_write=1) use cfg_max_payload and reads use cfg_max_read_req, each sampled when the job is accepted.
- R2: The byte pad of a chunk is its address mod 4, and it is subtracted from the size limit. A chunk is therefore at most limit - pad bytes long.
- R3: No chunk crosses a 4 KiB boundary: (desc_addr & 0xFFF) + desc_len <= 4096.
- R4: Each chunk starts where the previous one ended, and the chunk lengths sum to the job length. After the last chunk is taken, desc_valid drops and job_ready rises.
- R5: desc_is_64 is 1 exactly when desc_addr is above 0xFFFFFFFF.
- R6: With job_io=1 each chunk is at most 4 - (address mod 4) bytes, so desc_dwords is 1.
- R7: desc_dwords = ceil((pad + desc_len) / 4). desc_first_be has bit i set for byte lanes i >= pad. desc_last_be has bits 0..e-1 set, where e = (pad + len) mod 4; when e = 0 it is 4'b1111.
- R8: When desc_dwords is 1, desc_first_be is the AND of the two masks from R7 and desc_last_be is 4'b0000.
- R9: A job with length 0 is accepted and produces no descriptor.
- R10: While desc_valid is high and desc_ready is low, every descriptor field holds its value, and job_ready is low while descriptors are pending.
- R11: After reset job_ready is 1 and desc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Splitter is idle and takes the job |
| job_addr | input | ADDR_W | Job start byte address |
| job_len | input | LEN_W | Job length in bytes |
| job_write | input | 1 | 1 for a write, 0 for a read |
| job_io | input | 1 | IO-space job, chunks limited to one dword |
| cfg_max_payload | input | CODE_W | Write size code, limit 128 << code |
| cfg_max_read_req | input | CODE_W | Read size code, limit 128 << code |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_addr | output | ADDR_W | Chunk start address |
| desc_len | output | 13 | Chunk length in bytes |
| desc_dwords | output | 11 | Dwords spanned by the chunk |
| desc_first_be | output | 4 | First dword byte enables |
| desc_last_be | output | 4 | Last dword byte enables |
| desc_is_64 | output | 1 | 64-bit request format |
| desc_write | output | 1 | Direction of the job |
| desc_io | output | 1 | IO-space chunk |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a 16-bit length and 3-bit size codes. The 64-bit address lets chunks straddle the 0xFFFFFFFF line, so both request formats appear. The 16-bit length allows jobs long enough to hit the size cap and a 4 KiB boundary within one job. Random size codes are kept to 0..3 so that many jobs fit in the run, and a directed job uses code 7 together with a 4 KiB-aligned address so that the boundary cap, rather than the size limit, decides the chunk.

// File: rtl/dmas_pkg.sv
package dmas_pkg;
   localparam int PAGE_BYTES = 4096;
   localparam int PAGE_LOG2  = 12;
   localparam int CHUNK_W    = PAGE_LOG2 + 1;
   localparam int DW_W       = PAGE_LOG2 - 1;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_EMIT = 1'b1
   } dmas_state_e;

   typedef struct packed {
      logic [CHUNK_W-1:0] len;
      logic [DW_W-1:0]    dwords;
      logic [3:0]         first_be;
      logic [3:0]         last_be;
   } dmas_shape_t;
endpackage

// File: rtl/dmas_chunk_calc.sv
module dmas_chunk_calc
   import dmas_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int CODE_W = 3
) (
   input  logic [PAGE_LOG2-1:0] addr_lo,
   input  logic [LEN_W-1:0]     remaining,
   input  logic                 io_mode,
   input  logic [CODE_W-1:0]    size_code,
   output logic [CHUNK_W-1:0]   chunk_len
);
   localparam int LIM_W  = 8 + (1 << CODE_W);
   localparam int WIDE_W = (LEN_W > LIM_W) ? LEN_W : LIM_W;
   localparam int CALC_W = WIDE_W + 1;

   logic [1:0]        pad;
   logic [CALC_W-1:0] limit, limit_less_pad, to_page_end, io_cap, cap, rem_x, pick;
   logic              unused_hi;

   assign pad            = addr_lo[1:0];
   assign limit          = {{(CALC_W-8){1'b0}}, 8'd128} << size_code;
   assign limit_less_pad = limit - CALC_W'(pad);
   assign to_page_end    = CALC_W'(CHUNK_W'(PAGE_BYTES) - {1'b0, addr_lo});
   assign io_cap         = CALC_W'(3'd4 - {1'b0, pad});
   assign rem_x          = CALC_W'(remaining);

   always_comb begin
      if (io_mode)
         cap = io_cap;
      else if (limit_less_pad < to_page_end)
         cap = limit_less_pad;
      else
         cap = to_page_end;
      pick = (rem_x < cap) ? rem_x : cap;
   end

   assign chunk_len = pick[CHUNK_W-1:0];
   assign unused_hi = ^pick[CALC_W-1:CHUNK_W];
endmodule

// File: rtl/dmas_be_gen.sv
module dmas_be_gen
   import dmas_pkg::*;
(
   input  logic [1:0]         pad,
   input  logic [CHUNK_W-1:0] len,
   output dmas_shape_t        shape
);
   localparam int SPAN_W = CHUNK_W + 1;

   logic [SPAN_W-1:0] span, span_up;
   logic [1:0]        end_lane;
   logic [3:0]        first_raw, last_raw;
   logic [DW_W-1:0]   dw;
   logic              unused_bits;

   assign span      = {1'b0, len} + SPAN_W'(pad);
   assign span_up   = span + SPAN_W'(3);
   assign dw        = span_up[DW_W+1:2];
   assign end_lane  = span[1:0];
   assign first_raw = 4'hF << pad;
   assign last_raw  = (end_lane == 2'd0) ? 4'hF : (4'hF >> (3'd4 - {1'b0, end_lane}));
   assign unused_bits = ^{span_up[SPAN_W-1:DW_W+2], span_up[1:0]};

   always_comb begin
      shape.len    = len;
      shape.dwords = dw;
      if (dw == DW_W'(1)) begin
         shape.first_be = first_raw & last_raw;
         shape.last_be  = 4'h0;
      end else begin
         shape.first_be = first_raw;
         shape.last_be  = last_raw;
      end
   end
endmodule

// File: rtl/dmas_seq.sv
module dmas_seq
   import dmas_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 16,
   parameter int CODE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               job_valid,
   input  logic [ADDR_W-1:0]  job_addr,
   input  logic [LEN_W-1:0]   job_len,
   input  logic               job_write,
   input  logic               job_io,
   input  logic [CODE_W-1:0]  cfg_max_payload,
   input  logic [CODE_W-1:0]  cfg_max_read_req,
   input  logic               desc_ready,
   input  logic [CHUNK_W-1:0] chunk_len,
   output logic               job_ready,
   output logic               busy,
   output logic [ADDR_W-1:0]  cur_addr,
   output logic [LEN_W-1:0]   cur_rem,
   output logic               cur_write,
   output logic               cur_io,
   output logic [CODE_W-1:0]  cur_code
);
   dmas_state_e state;
   logic        take_job, take_desc, last_chunk;

   assign job_ready  = (state == ST_IDLE);
   assign busy       = (state == ST_EMIT);
   assign take_job   = job_valid && job_ready;
   assign take_desc  = busy && desc_ready;
   assign last_chunk = (cur_rem == LEN_W'(chunk_len));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_addr  <= '0;
         cur_rem   <= '0;
         cur_write <= 1'b0;
         cur_io    <= 1'b0;
         cur_code  <= '0;
      end else if (take_job) begin
         cur_addr  <= job_addr;
         cur_rem   <= job_len;
         cur_write <= job_write;
         cur_io    <= job_io;
         cur_code  <= job_write ? cfg_max_payload : cfg_max_read_req;
         state     <= (job_len != '0) ? ST_EMIT : ST_IDLE;
      end else if (take_desc) begin
         cur_addr <= cur_addr + ADDR_W'(chunk_len);
         cur_rem  <= cur_rem - LEN_W'(chunk_len);
         if (last_chunk)
            state <= ST_IDLE;
      end
   end
endmodule

// File: rtl/dma_req_splitter.sv
module dma_req_splitter
   import dmas_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 16,
   parameter int CODE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               job_valid,
   output logic               job_ready,
   input  logic [ADDR_W-1:0]  job_addr,
   input  logic [LEN_W-1:0]   job_len,
   input  logic               job_write,
   input  logic               job_io,
   input  logic [CODE_W-1:0]  cfg_max_payload,
   input  logic [CODE_W-1:0]  cfg_max_read_req,
   output logic               desc_valid,
   input  logic               desc_ready,
   output logic [ADDR_W-1:0]  desc_addr,
   output logic [CHUNK_W-1:0] desc_len,
   output logic [DW_W-1:0]    desc_dwords,
   output logic [3:0]         desc_first_be,
   output logic [3:0]         desc_last_be,
   output logic               desc_is_64,
   output logic               desc_write,
   output logic               desc_io
);
   if (ADDR_W < PAGE_LOG2 || ADDR_W > 64) begin : g_bad_addr
      $error("dma_req_splitter: ADDR_W must lie in 12..64");
   end
   if (LEN_W < CHUNK_W) begin : g_bad_len
      $error("dma_req_splitter: LEN_W must hold one full page");
   end
   if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code
      $error("dma_req_splitter: CODE_W must lie in 1..3");
   end

   logic               busy;
   logic [ADDR_W-1:0]  cur_addr;
   logic [LEN_W-1:0]   cur_rem;
   logic               cur_write, cur_io;
   logic [CODE_W-1:0]  cur_code;
   logic [CHUNK_W-1:0] chunk_len;
   dmas_shape_t        shape;

   dmas_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CODE_W(CODE_W)) u_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .job_valid        (job_valid),
      .job_addr         (job_addr),
      .job_len          (job_len),
      .job_write        (job_write),
      .job_io           (job_io),
      .cfg_max_payload  (cfg_max_payload),
      .cfg_max_read_req (cfg_max_read_req),
      .desc_ready       (desc_ready),
      .chunk_len        (chunk_len),
      .job_ready        (job_ready),
      .busy             (busy),
      .cur_addr         (cur_addr),
      .cur_rem          (cur_rem),
      .cur_write        (cur_write),
      .cur_io           (cur_io),
      .cur_code         (cur_code)
   );

   dmas_chunk_calc #(.LEN_W(LEN_W), .CODE_W(CODE_W)) u_calc (
      .addr_lo   (cur_addr[PAGE_LOG2-1:0]),
      .remaining (cur_rem),
      .io_mode   (cur_io),
      .size_code (cur_code),
      .chunk_len (chunk_len)
   );

   dmas_be_gen u_be (
      .pad   (cur_addr[1:0]),
      .len   (chunk_len),
      .shape (shape)
   );

   if (ADDR_W > 32) begin : g_wide
      assign desc_is_64 = |cur_addr[ADDR_W-1:32];
   end else begin : g_narrow
      assign desc_is_64 = 1'b0;
   end

   assign desc_valid    = busy;
   assign desc_addr     = cur_addr;
   assign desc_len      = shape.len;
   assign desc_dwords   = shape.dwords;
   assign desc_first_be = shape.first_be;
   assign desc_last_be  = shape.last_be;
   assign desc_write    = cur_write;
   assign desc_io       = cur_io;
endmodule

// File: rtl/dmas_checker.sv
module dmas_checker
   import dmas_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               job_ready,
   input logic               desc_valid,
   input logic               desc_ready,
   input logic [ADDR_W-1:0]  desc_addr,
   input logic [CHUNK_W-1:0] desc_len,
   input logic [DW_W-1:0]    desc_dwords,
   input logic [3:0]         desc_last_be,
   input logic               desc_io,
   input logic               desc_is_64
);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_len));

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> !job_ready);

   assert_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> ({1'b0, desc_addr[PAGE_LOG2-1:0]} + desc_len) <= CHUNK_W'(PAGE_BYTES));

   assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> desc_len != '0);

   assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_dwords == DW_W'(1) |-> desc_last_be == 4'h0);

   assert_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_io |-> desc_dwords == DW_W'(1));

   assert_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> desc_is_64 == ((desc_addr >> 32) != '0));
endmodule

bind dma_req_splitter dmas_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .job_ready    (job_ready),
   .desc_valid   (desc_valid),
   .desc_ready   (desc_ready),
   .desc_addr    (desc_addr),
   .desc_len     (desc_len),
   .desc_dwords  (desc_dwords),
   .desc_last_be (desc_last_be),
   .desc_io      (desc_io),
   .desc_is_64   (desc_is_64)
);

// File: tb/tb_dma_req_splitter.sv
module tb_dma_req_splitter;
   localparam int ADDR_W = 64;
   localparam int LEN_W  = 16;
   localparam int CODE_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              job_valid = 1'b0;
   logic              job_ready;
   logic [ADDR_W-1:0] job_addr = '0;
   logic [LEN_W-1:0]  job_len = '0;
   logic              job_write = 1'b0;
   logic              job_io = 1'b0;
   logic [CODE_W-1:0] cfg_max_payload = '0;
   logic [CODE_W-1:0] cfg_max_read_req = '0;
   logic              desc_valid;
   logic              desc_ready = 1'b0;
   logic [ADDR_W-1:0] desc_addr;
   logic [12:0]       desc_len;
   logic [10:0]       desc_dwords;
   logic [3:0]        desc_first_be, desc_last_be;
   logic              desc_is_64, desc_write, desc_io;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dma_req_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CODE_W(CODE_W)) dut (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int model_len(longint unsigned a, int rem, bit io, int code);
      int pad = int'(a % 4);
      int cap;
      int page = 4096 - int'(a % 4096);
      if (io) cap = 4 - pad;
      else begin
         cap = (128 << code) - pad;
         if (page < cap) cap = page;
      end
      return (rem < cap) ? rem : cap;
   endfunction

   function automatic int model_dw(int pad, int len);
      return (pad + len + 3) / 4;
   endfunction

   function automatic logic [3:0] model_first(int pad, int len);
      logic [3:0] f = 4'hF << pad;
      int e = (pad + len) % 4;
      logic [3:0] l = (e == 0) ? 4'hF : 4'((1 << e) - 1);
      return (model_dw(pad, len) == 1) ? (f & l) : f;
   endfunction

   function automatic logic [3:0] model_last(int pad, int len);
      int e = (pad + len) % 4;
      if (model_dw(pad, len) == 1) return 4'h0;
      return (e == 0) ? 4'hF : 4'((1 << e) - 1);
   endfunction

   task automatic run_job(input longint unsigned a, input int len, input bit wr,
                          input bit io, input int mps, input int mrr, input bit stall);
      longint unsigned ma = a;
      int rem = len;
      int code = wr ? mps : mrr;
      int sum = 0;
      @(negedge clk);
      cfg_max_payload  = CODE_W'(mps);
      cfg_max_read_req = CODE_W'(mrr);
      job_addr = a; job_len = LEN_W'(len); job_write = wr; job_io = io;
      job_valid = 1'b1;
      #1;
      check(job_ready == 1'b1, "R4", "job_ready when idle", job_ready, 1);
      @(negedge clk);
      job_valid = 1'b0;
      cfg_max_payload  = CODE_W'($urandom % 8);
      cfg_max_read_req = CODE_W'($urandom % 8);
      while (rem > 0) begin
         int el = model_len(ma, rem, io, code);
         int pad = int'(ma % 4);
         bit got = 1'b0;
         int guard = 0;
         while (!got) begin
            desc_ready = stall ? ($urandom % 4 == 0) : ($urandom % 2 == 1);
            #1;
            check(desc_valid == 1'b1, "R4", "desc_valid while pending", desc_valid, 1);
            check(job_ready == 1'b0, "R10", "job_ready while pending", job_ready, 0);
            check(desc_addr == ma, "R4", "desc_addr", desc_addr, ma);
            check(desc_len == 13'(el), "R1 R2 R3 R6", "desc_len", desc_len, el);
            check(desc_dwords == 11'(model_dw(pad, el)), "R7", "desc_dwords",
                  desc_dwords, model_dw(pad, el));
            check(desc_first_be == model_first(pad, el), "R7 R8", "desc_first_be",
                  desc_first_be, model_first(pad, el));
            check(desc_last_be == model_last(pad, el), "R7 R8", "desc_last_be",
                  desc_last_be, model_last(pad, el));
            check(desc_is_64 == (ma > 64'hFFFF_FFFF), "R5", "desc_is_64",
                  desc_is_64, ma > 64'hFFFF_FFFF);
            check(desc_write == wr && desc_io == io, "R10", "desc kind",
                  {desc_write, desc_io}, {wr, io});
            got = desc_ready;
            guard++;
            if (guard > 200) begin
               check(1'b0, "R4", "descriptor never taken", 0, 1);
               return;
            end
            @(negedge clk);
         end
         ma += longint'(el);
         rem -= el;
         sum += el;
      end
      desc_ready = 1'b0;
      #1;
      check(sum == len, "R4", "chunk sum", sum, len);
      check(desc_valid == 1'b0, (len == 0) ? "R9" : "R4", "desc_valid after job", desc_valid, 0);
      check(job_ready == 1'b1, (len == 0) ? "R9" : "R4", "job_ready after job", job_ready, 1);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check(job_ready == 1'b1, "R11", "job_ready in reset", job_ready, 1);
      check(desc_valid == 1'b0, "R11", "desc_valid in reset", desc_valid, 0);
      rst_n = 1'b1;
      // R3: boundary split 0xFFE + 10 bytes, R8 merged single-dword enables
      run_job(64'h0FFE, 10, 1'b1, 1'b0, 0, 5, 1'b1);
      // R5 R7: above 4 GiB, pad 3
      run_job(64'h1_0000_0003, 5, 1'b0, 1'b0, 5, 0, 1'b0);
      // R5: job crossing the 0xFFFFFFFF line
      run_job(64'hFFFF_FFF0, 300, 1'b1, 1'b0, 0, 0, 1'b0);
      // R6: IO mode 0x101 + 6
      run_job(64'h101, 6, 1'b1, 1'b1, 7, 7, 1'b0);
      // R9: zero length
      run_job(64'h2000, 0, 1'b0, 1'b0, 2, 2, 1'b0);
      // R1: write uses payload code, read uses read code
      run_job(64'h0, 1000, 1'b1, 1'b0, 1, 3, 1'b1);
      run_job(64'h0, 1000, 1'b0, 1'b0, 1, 3, 1'b0);
      // R3: largest code, page boundary decides
      run_job(64'h3000, 9000, 1'b0, 1'b0, 0, 7, 1'b0);
      for (int i = 0; i < 80; i++) begin
         longint unsigned a;
         int len;
         bit io = ($urandom % 6 == 0);
         a = {32'($urandom % 3), 20'($urandom), 12'($urandom % 2 ? 12'hFF0 + 12'($urandom % 16) : 12'($urandom))};
         len = io ? int'($urandom % 12) : int'($urandom % 700);
         run_job(a, len, 1'($urandom), io, int'($urandom % 4), int'($urandom % 4), 1'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule